// File: doc/BRIEF.md
# Interleaved Grid-Scan Refresh Controller for a Dot-Matrix Fluorescent Display

This block refreshes a multiplexed vacuum-fluorescent dot matrix of 26 anode rows by 256 columns with no help from the host. The panel's grids each carry two columns. Odd-numbered grids hold their columns in the order D then A, and even-numbered grids hold them in the order B then C. A host fills a dual-port memory with one 32-bit word per column, and only the low row bits of each word are used. The controller fetches the columns it needs through its own read port. Column `c` sits at byte address `4*c`, and its data returns one cycle after the read request.

A frame has 128 steps. At step `k` the controller drives grids `k` and `k+1`, counting grids from 1, so step 0 drives grid 1 alone. Only the two columns that face each other across the boundary between those grids are lit: column `2k-1` and column `2k`. The outer columns stay dark, and so do grid 129 and column 255. One serial stream feeds driver groups A and C, and a second feeds groups B and D. The input registers of both groups in a pair therefore hold the same bits. Which pair shows them is chosen only by the output enables. While step `k` is on view, the data for step `k+1` is shifted in on a common shift clock together with the grid pattern. At the end of the step the anodes are blanked, the drivers are strobed, and the pair for the new step is enabled.

The step period is a parameter in clock cycles. About 104 µs per step gives a refresh of roughly 75 Hz.

Top module: `vfd_scan_top`

## Requirements
- R1: While `rst_n` is low, `en_ab`, `en_cd`, `drv_strobe`, `drv_sclk` and `mem_rd_en` are low. After release the scan starts again at step 0, so the first enabled step lights grid bit 0 only and enables the C/D pair.
- R2: After the strobe that opens step `k`, the anode groups fed by `anode_sd_ac` hold column `2k-1` (all zero when `k`=0). The groups fed by `anode_sd_bd` hold column `2k`. Driver output `j` carries bit `j` of the column word for `j` < ROWS and is zero above that. Words are read at byte address `4*column`, with the data one cycle after `mem_rd_en`.
- R3: After the strobe that opens step `k`, grid driver bit `k` and bit `k-1` are set and every other bit is clear. At step 0 only bit 0 is set. Grid number `g` maps to bit `g-1`.
- R4: An even step enables only the C/D pair (`en_cd`), an odd step enables only the A/B pair (`en_ab`), and the two enables are never high together.
- R5: `drv_strobe` is high only while both enables are low. Both enables are low in the cycle before the strobe cycle and in the strobe cycle itself. The pair for the new step rises in the cycle after the strobe.
- R6: Rising edges of `drv_strobe` are exactly STEP_CYCLES cycles apart, and the step index wraps from STEPS-1 back to 0.
- R7: Between two strobes `drv_sclk` rises exactly max(GRID_BITS, DRV_BITS) times, never while `drv_strobe` is high. Each serial bit is stable across its rising edge, and the highest bit position is sent first, so the last bit shifted lands in driver position 0.
- R8: The enables change only at the blanking cycle and just after a strobe, so each step has exactly one enable rise and one enable fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rd_en | output | 1 | Read request to the column memory |
| mem_rd_addr | output | ADDR_W | Byte address of the column word |
| mem_rd_data | input | DATA_W | Column word, valid one cycle after the request |
| anode_sd_ac | output | 1 | Serial anode data shared by groups A and C |
| anode_sd_bd | output | 1 | Serial anode data shared by groups B and D |
| grid_sd | output | 1 | Serial grid pattern data |
| drv_sclk | output | 1 | Shift clock for all drivers |
| drv_strobe | output | 1 | Moves driver input registers to outputs |
| en_ab | output | 1 | Output enable of anode groups A and B |
| en_cd | output | 1 | Output enable of anode groups C and D |

## Verification
The step timer wraps in cycle T. The enables drop one cycle later, the strobe is high in cycle T+2, and the new pair rises in cycle T+3. The bench samples on the falling clock edge and keeps a short history of the enables, so each of these results is checked in the exact cycle it is due. Driver contents are checked in the sample where the strobe falls, after the bench's driver models have latched at the strobe's rising edge. Strobe spacing, shift-clock counts and enable transitions are counted per step over more than two full frames of a small configuration. The same checks run again after a reset taken in the middle of a step.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef enum logic [2:0] {
    SEQ_FETCH_X,
    SEQ_FETCH_Y,
    SEQ_CAPT,
    SEQ_SHIFT,
    SEQ_WAIT,
    SEQ_BLANK,
    SEQ_STROBE
  } seq_state_e;

  typedef struct packed {
    logic ab;
    logic cd;
  } pair_en_t;

  function automatic int unsigned larger_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vfd_step_timer.sv
module vfd_step_timer #(
  parameter int STEP_CYCLES = 1300,
  localparam int TMR_W = $clog2(STEP_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == TMR_W'(STEP_CYCLES - 1));

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

endmodule

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
  import vfd_scan_pkg::*;
#(
  parameter int STEPS = 128,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ser_done,
  output seq_state_e        state,
  output logic [STEP_W-1:0] load_step,
  output logic              ser_start,
  output logic              strobe,
  output pair_en_t          pair_en
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d, step_inc;
  logic              strobe_q, strobe_d;
  pair_en_t          en_q, en_d;
  logic              step_last;

  assign step_last = (step_q == STEP_W'(STEPS - 1));

  always_comb begin
    step_inc = step_q + 1'b1;
    if (step_last) step_inc = '0;
  end

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    strobe_d  = 1'b0;
    en_d      = en_q;
    ser_start = 1'b0;
    unique case (state_q)
      SEQ_FETCH_X: state_d = SEQ_FETCH_Y;
      SEQ_FETCH_Y: state_d = SEQ_CAPT;
      SEQ_CAPT: begin
        ser_start = 1'b1;
        state_d   = SEQ_SHIFT;
      end
      SEQ_SHIFT: begin
        if (ser_done) state_d = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (tick) begin
          state_d = SEQ_BLANK;
          en_d    = '0;
        end
      end
      SEQ_BLANK: begin
        state_d  = SEQ_STROBE;
        strobe_d = 1'b1;
      end
      SEQ_STROBE: begin
        state_d  = SEQ_FETCH_X;
        en_d.cd  = ~step_q[0];
        en_d.ab  = step_q[0];
        step_d   = step_inc;
      end
      default: state_d = SEQ_FETCH_X;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_FETCH_X;
      step_q   <= '0;
      strobe_q <= 1'b0;
      en_q     <= '0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      strobe_q <= strobe_d;
      en_q     <= en_d;
    end
  end

  assign state     = state_q;
  assign load_step = step_q;
  assign strobe    = strobe_q;
  assign pair_en   = en_q;

endmodule

// File: rtl/vfd_col_fetch.sv
module vfd_col_fetch
  import vfd_scan_pkg::*;
#(
  parameter int ROWS   = 26,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int STEPS  = 128,
  localparam int STEP_W = $clog2(STEPS),
  localparam int COL_W  = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [STEP_W-1:0] load_step,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [ROWS-1:0]   col_x,
  output logic [ROWS-1:0]   col_y
);

  logic [COL_W-1:0]   idx_x, idx_y;
  logic [COL_W+1:0]   byte_addr;
  logic               first_step;
  logic [ROWS-1:0]    x_q, x_d, y_q, y_d;
  logic               x_we, y_we;

  assign first_step = (load_step == '0);
  assign idx_y      = {load_step, 1'b0};
  assign idx_x      = idx_y - 1'b1;

  always_comb begin
    mem_rd_en = 1'b0;
    byte_addr = '0;
    unique case (state)
      SEQ_FETCH_X: begin
        mem_rd_en = ~first_step;
        byte_addr = {idx_x, 2'b00};
      end
      SEQ_FETCH_Y: begin
        mem_rd_en = 1'b1;
        byte_addr = {idx_y, 2'b00};
      end
      default: ;
    endcase
  end

  assign mem_rd_addr = ADDR_W'(byte_addr);

  assign x_we = (state == SEQ_FETCH_Y);
  assign y_we = (state == SEQ_CAPT);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (x_we) x_d = first_step ? '0 : mem_rd_data[ROWS-1:0];
    if (y_we) y_d = mem_rd_data[ROWS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  generate
    if (DATA_W > ROWS) begin : g_spare
      logic data_unused;
      assign data_unused = ^mem_rd_data[DATA_W-1:ROWS];
    end
  endgenerate

  assign col_x = x_q;
  assign col_y = y_q;

endmodule

// File: rtl/vfd_serializer.sv
module vfd_serializer #(
  parameter int ROWS      = 26,
  parameter int SHIFT_LEN = 128,
  parameter int GRID_BITS = 128,
  parameter int STEPS     = 128,
  localparam int STEP_W = $clog2(STEPS),
  localparam int IDX_W  = $clog2(SHIFT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] load_step,
  input  logic [ROWS-1:0]   col_x,
  input  logic [ROWS-1:0]   col_y,
  output logic              done,
  output logic              sclk,
  output logic              sd_ac,
  output logic              sd_bd,
  output logic              sd_grid
);

  logic [SHIFT_LEN-1:0] x_pad, y_pad, grid_pat;
  logic                 active_q, active_d;
  logic                 ph_q, ph_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 sclk_q, sclk_d;
  logic                 ac_q, ac_d, bd_q, bd_d, gr_q, gr_d;

  assign x_pad = SHIFT_LEN'(col_x);
  assign y_pad = SHIFT_LEN'(col_y);

  generate
    for (genvar gi = 0; gi < SHIFT_LEN; gi++) begin : g_grid
      if (gi < GRID_BITS) begin : g_used
        assign grid_pat[gi] = (int'(load_step) == gi) ||
                              ((load_step != '0) && (int'(load_step) == gi + 1));
      end else begin : g_pad
        assign grid_pat[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    active_d = active_q;
    ph_d     = ph_q;
    idx_d    = idx_q;
    sclk_d   = 1'b0;
    ac_d     = ac_q;
    bd_d     = bd_q;
    gr_d     = gr_q;
    done     = 1'b0;
    if (start) begin
      active_d = 1'b1;
      ph_d     = 1'b0;
      idx_d    = IDX_W'(SHIFT_LEN - 1);
    end else if (active_q) begin
      if (!ph_q) begin
        ac_d = x_pad[idx_q];
        bd_d = y_pad[idx_q];
        gr_d = grid_pat[idx_q];
        ph_d = 1'b1;
      end else begin
        sclk_d = 1'b1;
        ph_d   = 1'b0;
        if (idx_q == '0) begin
          active_d = 1'b0;
          done     = 1'b1;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= 1'b0;
      idx_q    <= '0;
      sclk_q   <= 1'b0;
      ac_q     <= 1'b0;
      bd_q     <= 1'b0;
      gr_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      ph_q     <= ph_d;
      idx_q    <= idx_d;
      sclk_q   <= sclk_d;
      ac_q     <= ac_d;
      bd_q     <= bd_d;
      gr_q     <= gr_d;
    end
  end

  assign sclk    = sclk_q;
  assign sd_ac   = ac_q;
  assign sd_bd   = bd_q;
  assign sd_grid = gr_q;

endmodule

// File: rtl/vfd_scan_top.sv
module vfd_scan_top
  import vfd_scan_pkg::*;
#(
  parameter int ROWS        = 26,
  parameter int DRV_BITS    = 32,
  parameter int STEPS       = 128,
  parameter int GRID_BITS   = 128,
  parameter int STEP_CYCLES = 1300,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              anode_sd_ac,
  output logic              anode_sd_bd,
  output logic              grid_sd,
  output logic              drv_sclk,
  output logic              drv_strobe,
  output logic              en_ab,
  output logic              en_cd
);

  localparam int STEP_W    = $clog2(STEPS);
  localparam int SHIFT_LEN = int'(larger_of(GRID_BITS, DRV_BITS));

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              tick;
  logic              ser_start, ser_done;
  seq_state_e        state;
  logic [STEP_W-1:0] load_step;
  logic [ROWS-1:0]   col_x, col_y;
  pair_en_t          pair_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  vfd_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  vfd_scan_seq #(.STEPS(STEPS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .ser_done  (ser_done),
    .state     (state),
    .load_step (load_step),
    .ser_start (ser_start),
    .strobe    (drv_strobe),
    .pair_en   (pair_en)
  );

  vfd_col_fetch #(
    .ROWS(ROWS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEPS(STEPS)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state       (state),
    .load_step   (load_step),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .col_x       (col_x),
    .col_y       (col_y)
  );

  vfd_serializer #(
    .ROWS(ROWS), .SHIFT_LEN(SHIFT_LEN), .GRID_BITS(GRID_BITS), .STEPS(STEPS)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (ser_start),
    .load_step (load_step),
    .col_x     (col_x),
    .col_y     (col_y),
    .done      (ser_done),
    .sclk      (drv_sclk),
    .sd_ac     (anode_sd_ac),
    .sd_bd     (anode_sd_bd),
    .sd_grid   (grid_sd)
  );

  assign en_ab = pair_en.ab;
  assign en_cd = pair_en.cd;

endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter int STEP_CYCLES = 1300,
  parameter int STEPS       = 128,
  parameter int ADDR_W      = 10,
  localparam int GAP_W = $clog2(STEP_CYCLES + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              drv_sclk,
  input logic              drv_strobe,
  input logic              en_ab,
  input logic              en_cd
);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (drv_strobe) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_ab && en_cd)); // R4

  AST_STROBE_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    drv_strobe |-> (!en_ab && !en_cd)); // R5

  AST_AB_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_ab) |-> $past(drv_strobe)); // R8

  AST_CD_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_cd) |-> $past(drv_strobe)); // R8

  AST_AB_FALL_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_ab) |=> drv_strobe); // R5

  AST_CD_FALL_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_cd) |=> drv_strobe); // R5

  AST_STEP_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_strobe) && seen_q) |-> (gap_q == GAP_W'(STEP_CYCLES - 1))); // R6

  AST_SCLK_APART: assert property (@(posedge clk) disable iff (!rst_n)
    drv_sclk |-> !drv_strobe); // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00)); // R2

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (int'(mem_rd_addr) < 8 * STEPS)); // R2

endmodule

bind vfd_scan_top vfd_scan_chk #(
  .STEP_CYCLES(STEP_CYCLES), .STEPS(STEPS), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .drv_sclk    (drv_sclk),
  .drv_strobe  (drv_strobe),
  .en_ab       (en_ab),
  .en_cd       (en_cd)
);

// File: tb/tb_vfd_scan_top.sv
`timescale 1ns/1ps
module tb_vfd_scan_top;

  localparam int CLK_PERIOD  = 10;
  localparam int ROWS        = 6;
  localparam int DRV_BITS    = 8;
  localparam int STEPS       = 8;
  localparam int GRID_BITS   = 8;
  localparam int STEP_CYCLES = 40;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 10;
  localparam int SHIFT_LEN   = (GRID_BITS > DRV_BITS) ? GRID_BITS : DRV_BITS;

  logic              clk;
  logic              rst_n;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0] mem_rd_data;
  logic              anode_sd_ac, anode_sd_bd, grid_sd;
  logic              drv_sclk, drv_strobe, en_ab, en_cd;

  int total = 0;
  int bad   = 0;

  vfd_scan_top #(
    .ROWS(ROWS), .DRV_BITS(DRV_BITS), .STEPS(STEPS), .GRID_BITS(GRID_BITS),
    .STEP_CYCLES(STEP_CYCLES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .anode_sd_ac(anode_sd_ac), .anode_sd_bd(anode_sd_bd),
    .grid_sd(grid_sd), .drv_sclk(drv_sclk), .drv_strobe(drv_strobe),
    .en_ab(en_ab), .en_cd(en_cd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [DATA_W-1:0] col_word(int c);
    logic [31:0] v;
    v = (32'(c) * 32'h9E37_79B1) ^ (32'(c) << 3) ^ 32'hA5C3_0F00;
    return DATA_W'(v);
  endfunction

  function automatic logic [63:0] col_rows(int c);
    logic [DATA_W-1:0] w;
    w = col_word(c);
    return 64'(w[ROWS-1:0]);
  endfunction

  // column memory, one cycle read latency, word address = byte address / 4
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= col_word(int'(mem_rd_addr >> 2));
  end

  // behavioural driver models: shift on sclk rise, present on strobe rise
  logic [DRV_BITS-1:0]  sh_a, sh_b, sh_c, sh_d, out_a, out_b, out_c, out_d;
  logic [GRID_BITS-1:0] sh_g, out_g;

  always @(posedge drv_sclk) begin
    sh_a <= {sh_a[DRV_BITS-2:0], anode_sd_ac};
    sh_c <= {sh_c[DRV_BITS-2:0], anode_sd_ac};
    sh_b <= {sh_b[DRV_BITS-2:0], anode_sd_bd};
    sh_d <= {sh_d[DRV_BITS-2:0], anode_sd_bd};
    sh_g <= {sh_g[GRID_BITS-2:0], grid_sd};
  end

  always @(posedge drv_strobe) begin
    out_a <= sh_a;
    out_b <= sh_b;
    out_c <= sh_c;
    out_d <= sh_d;
    out_g <= sh_g;
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor state
  int         exp_step = 0;
  bit         seen = 0;
  int         gap = 0;
  int         sclk_cnt = 0;
  int         en_tr = 0;
  int         steps_done = 0;
  int         steps_since_rst = 0;
  logic [1:0] en_h1 = '0, en_h2 = '0;
  logic       prev_strobe = 1'b0, prev_sclk = 1'b0;

  always @(negedge clk) begin
    logic [1:0]  cur_en;
    logic [1:0]  pair_exp, prev_pair;
    logic [63:0] ex, ey, eg;
    int          ps;
    if (!rst_n) begin
      exp_step = 0; seen = 0; gap = 0; sclk_cnt = 0; en_tr = 0;
      steps_since_rst = 0; en_h1 = '0; en_h2 = '0;
      prev_strobe = 1'b0; prev_sclk = 1'b0;
    end else begin
      cur_en = {en_ab, en_cd};
      if (drv_sclk && !prev_sclk) sclk_cnt++;
      if (cur_en != en_h1) en_tr++;
      gap++;
      if (drv_strobe && !prev_strobe) begin
        check(cur_en == 2'b00, "R5", "enables during strobe", 64'(cur_en), 64'd0);
        check(en_h1 == 2'b00, "R5", "enables in blank cycle", 64'(en_h1), 64'd0);
        check(sclk_cnt == SHIFT_LEN, "R7", "shift clocks per step", 64'(sclk_cnt), 64'(SHIFT_LEN));
        if (seen) begin
          ps = (exp_step + STEPS - 1) % STEPS;
          prev_pair = (ps % 2 == 0) ? 2'b01 : 2'b10;
          check(gap == STEP_CYCLES, "R6", "strobe spacing", 64'(gap), 64'(STEP_CYCLES));
          check(en_h2 == prev_pair, "R5", "pair held until blank", 64'(en_h2), 64'(prev_pair));
          check(en_tr == 1, "R8", "enable changes inside step", 64'(en_tr), 64'd1);
        end
        gap = 0;
        sclk_cnt = 0;
      end
      if (!drv_strobe && prev_strobe) begin
        pair_exp = (exp_step % 2 == 0) ? 2'b01 : 2'b10;
        ex = (exp_step == 0) ? 64'd0 : col_rows(2 * exp_step - 1);
        ey = col_rows(2 * exp_step);
        eg = (64'd1 << exp_step) | ((exp_step > 0) ? (64'd1 << (exp_step - 1)) : 64'd0);
        check(cur_en == pair_exp, "R4", "pair enabled after strobe", 64'(cur_en), 64'(pair_exp));
        check(64'(out_a) == ex, "R2", "group A columns", 64'(out_a), ex);
        check(64'(out_c) == ex, "R2", "group C columns", 64'(out_c), ex);
        check(64'(out_b) == ey, "R2", "group B columns", 64'(out_b), ey);
        check(64'(out_d) == ey, "R2", "group D columns", 64'(out_d), ey);
        check(64'(out_g) == eg, "R3", "grid pattern", 64'(out_g), eg);
        if (steps_since_rst == 0) begin
          check(cur_en == 2'b01 && out_g == GRID_BITS'(1), "R1", "scan restarts at step 0",
                {62'd0, cur_en}, 64'd1);
        end
        en_tr = 0;
        exp_step = (exp_step + 1) % STEPS;
        seen = 1;
        steps_done++;
        steps_since_rst++;
      end
      en_h2 = en_h1;
      en_h1 = cur_en;
      prev_strobe = drv_strobe;
      prev_sclk = drv_sclk;
    end
  end

  task automatic check_reset_outputs(string what);
    check({en_ab, en_cd, drv_strobe, drv_sclk, mem_rd_en} == 5'b0, "R1", what,
          64'({en_ab, en_cd, drv_strobe, drv_sclk, mem_rd_en}), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_reset_outputs("outputs held in reset");
    rst_n = 1'b1;
    // more than two full frames, R6 wrap included
    while (steps_done < 2 * STEPS + 2) @(negedge clk);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_outputs("outputs blanked by mid-step reset");
    repeat (3) @(negedge clk);
    check_reset_outputs("outputs still blank in reset");
    rst_n = 1'b1;
    while (steps_done < 2 * STEPS + 2 + STEPS + 3) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", steps_done, 3 * STEPS + 5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule